// File: doc/BRIEF.md
# Serial Link Break and Power-Up Flush Sequencer

This block drives the clock and data pins of a two-wire serial management link during the two housekeeping sequences that come before normal command traffic. The first is a power-up flush: it turns on the link's enable, mux-select and level-translator direction outputs, then clocks the link for a long run with the data line idle (high), so any stale bits held in the slave are pushed out. The second is a link break: a data-low pulse with a fixed shape. A short idle lead-in comes first, then a long low stretch, an echo delay, and a very long idle stretch in which the slave finishes its reset. A final silent wait, counted in system clocks, gives the slave logic time to settle before completion is reported.

The link clock runs at half the system clock. Each link clock period is one system cycle low followed by one system cycle high. The data line only changes in the low half. A requester pulses one of the two start inputs while the block is idle. `busy` stays high until the one-cycle `done` pulse, and any start seen while busy is dropped. Command traffic on the link is handled elsewhere.

Top module: `lnk_brk_init_seq`

## Requirements
- R1: After reset, busy and done are 0, link_clk and link_data are 1, and link_en, link_mux and link_dir are 0.
- R2: When an init request is accepted, link_en, link_mux and link_dir go to 1 in the next cycle and stay at 1 until reset.
- R3: The init sequence produces exactly 5000 rising link_clk edges with link_data at 1, and raises done in the system cycle after the last of those edges.
- R4: A break begins with exactly 50 rising link_clk edges with link_data at 1.
- R5: The break then produces exactly 256 rising link_clk edges with link_data at 0.
- R6: The break then produces 16 echo edges followed by 16000 settle edges, all with link_data at 1, for 16016 consecutive high-data edges in all.
- R7: After the last settle edge, link_clk and link_data stay at 1 for WAIT_CYC system cycles (default 25000, 200 µs at 125 MHz), and done rises WAIT_CYC+1 cycles after that last edge.
- R8: busy is 1 from the cycle after a start is accepted up to and including the done cycle. done lasts one cycle, and busy is 0 in the cycle after done.
- R9: A break or init request that arrives while busy is ignored. The running waveform is unchanged, and no new sequence starts after done.
- R10: If break and init are requested in the same idle cycle, the break runs and the init request is dropped, so link_en stays 0.
- R11: link_data changes only while link_clk is 0. While idle, link_clk and link_data are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_start | input | 1 | Request a link break sequence |
| init_start | input | 1 | Request the power-up flush sequence |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| link_clk | output | 1 | Serial link clock pin |
| link_data | output | 1 | Serial link data pin (1 = idle) |
| link_en | output | 1 | Link enable output |
| link_mux | output | 1 | Link mux-select output |
| link_dir | output | 1 | Level translator direction (1 = drive) |

## Verification
Two kinds of collision are provoked. The first test raises break and init in the same idle cycle. It is judged by the resulting data waveform, which must have the break's shape, and by link_enable staying low throughout. The second collision injects both requests again in the middle of a running break. It is judged by the edge-run lengths staying at 50, 256 and 16016, by the silent wait keeping its length, and by busy staying low after done. A monitor sorts every rising link clock edge into runs by data level, so each phase length is measured at the pins.

// File: rtl/lnk_brk_pkg.sv
package lnk_brk_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FLUSH,
    PH_PREP,
    PH_LOW,
    PH_ECHO,
    PH_SETTLE,
    PH_WAIT,
    PH_DONE
  } lnk_phase_e;
endpackage

// File: rtl/lnk_half_tick.sv
module lnk_half_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half
);
  logic half_nxt;

  always_comb begin
    half_nxt = 1'b0;
    if (run) half_nxt = ~half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half <= 1'b0;
    else        half <= half_nxt;
  end

  // R11
  half_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !half);
endmodule

// File: rtl/lnk_down_cnt.sv
module lnk_down_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  assign cnt_en = load | dec;

  always_comb begin
    cnt_nxt = cnt_q;
    if (load)     cnt_nxt = load_val;
    else if (dec) cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign zero = (cnt_q == '0);

  // R7
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !zero);
endmodule

// File: rtl/lnk_seq_ctrl.sv
module lnk_seq_ctrl
  import lnk_brk_pkg::*;
#(
  parameter int CW         = 16,
  parameter int FLUSH_CYC  = 5000,
  parameter int PREP_CYC   = 50,
  parameter int LOW_CYC    = 256,
  parameter int ECHO_CYC   = 16,
  parameter int SETTLE_CYC = 16000,
  parameter int WAIT_CYC   = 25000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          brk_req,
  input  logic          init_req,
  input  logic          half,
  input  logic          cnt_zero,
  output lnk_phase_e    phase,
  output logic          run,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          cnt_dec
);
  localparam logic [CW-1:0] L_FLUSH  = CW'(FLUSH_CYC - 1);
  localparam logic [CW-1:0] L_PREP   = CW'(PREP_CYC - 1);
  localparam logic [CW-1:0] L_LOW    = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] L_ECHO   = CW'(ECHO_CYC - 1);
  localparam logic [CW-1:0] L_SETTLE = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] L_WAIT   = CW'(WAIT_CYC - 1);

  lnk_phase_e phase_nxt;

  assign run = (phase == PH_FLUSH) || (phase == PH_PREP) || (phase == PH_LOW) ||
               (phase == PH_ECHO)  || (phase == PH_SETTLE);

  always_comb begin
    phase_nxt = phase;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cnt_dec   = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (brk_req) begin
          phase_nxt = PH_PREP;  cnt_load = 1'b1; cnt_val = L_PREP;
        end else if (init_req) begin
          phase_nxt = PH_FLUSH; cnt_load = 1'b1; cnt_val = L_FLUSH;
        end
      end
      PH_FLUSH, PH_PREP, PH_LOW, PH_ECHO, PH_SETTLE: begin
        if (half) begin
          if (!cnt_zero) cnt_dec = 1'b1;
          else begin
            cnt_load = 1'b1;
            unique case (phase)
              PH_FLUSH: phase_nxt = PH_DONE;
              PH_PREP:  begin phase_nxt = PH_LOW;    cnt_val = L_LOW;    end
              PH_LOW:   begin phase_nxt = PH_ECHO;   cnt_val = L_ECHO;   end
              PH_ECHO:  begin phase_nxt = PH_SETTLE; cnt_val = L_SETTLE; end
              default:  begin phase_nxt = PH_WAIT;   cnt_val = L_WAIT;   end
            endcase
          end
        end
      end
      PH_WAIT: begin
        if (cnt_zero) phase_nxt = PH_DONE;
        else          cnt_dec   = 1'b1;
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nxt;
  end

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_DONE) |=> (phase != PH_IDLE));
endmodule

// File: rtl/lnk_brk_init_seq.sv
module lnk_brk_init_seq
  import lnk_brk_pkg::*;
#(
  parameter int FLUSH_CYC  = 5000,
  parameter int PREP_CYC   = 50,
  parameter int LOW_CYC    = 256,
  parameter int ECHO_CYC   = 16,
  parameter int SETTLE_CYC = 16000,
  parameter int WAIT_CYC   = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_start,
  input  logic init_start,
  output logic busy,
  output logic done,
  output logic link_clk,
  output logic link_data,
  output logic link_en,
  output logic link_mux,
  output logic link_dir
);
  localparam int M0 = (FLUSH_CYC > PREP_CYC) ? FLUSH_CYC : PREP_CYC;
  localparam int M1 = (LOW_CYC > ECHO_CYC) ? LOW_CYC : ECHO_CYC;
  localparam int M2 = (SETTLE_CYC > WAIT_CYC) ? SETTLE_CYC : WAIT_CYC;
  localparam int M3 = (M0 > M1) ? M0 : M1;
  localparam int MAXC = (M3 > M2) ? M3 : M2;
  localparam int CW = $clog2(MAXC + 1);

  lnk_phase_e    phase;
  logic          half, run, cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0] cnt_val;
  logic          ctl_on, ctl_nxt, ctl_en;

  lnk_half_tick u_half (
    .clk(clk), .rst_n(rst_n), .run(run), .half(half)
  );

  lnk_down_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  lnk_seq_ctrl #(
    .CW(CW), .FLUSH_CYC(FLUSH_CYC), .PREP_CYC(PREP_CYC), .LOW_CYC(LOW_CYC),
    .ECHO_CYC(ECHO_CYC), .SETTLE_CYC(SETTLE_CYC), .WAIT_CYC(WAIT_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_start), .init_req(init_start),
    .half(half), .cnt_zero(cnt_zero), .phase(phase), .run(run),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_dec(cnt_dec)
  );

  // control outputs latch on when an init is accepted (break has priority)
  assign ctl_en  = (phase == PH_IDLE) && init_start && !brk_start;
  assign ctl_nxt = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_on <= 1'b0;
    else if (ctl_en) ctl_on <= ctl_nxt;
  end

  assign busy      = (phase != PH_IDLE);
  assign done      = (phase == PH_DONE);
  assign link_clk  = run ? half : 1'b1;
  assign link_data = (phase != PH_LOW);
  assign link_en   = ctl_on;
  assign link_mux  = ctl_on;
  assign link_dir  = ctl_on;

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R11
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_data) |-> !link_clk);
  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (link_clk && link_data));
  // R2
  ctl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_en |=> (link_en && link_mux && link_dir));
endmodule

// File: tb/sim_lnk_brk_init_seq.sv
`timescale 1ns/1ps
module sim_lnk_brk_init_seq;
  localparam int WAIT_CYC = 25000;

  logic clk, rst_n, brk_start, init_start;
  logic busy, done, link_clk, link_data, link_en, link_mux, link_dir;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // rising-edge run log
  int  run_len [8];
  bit  run_lvl [8];
  int  nruns, cur_len, since_rise, done_k, done_seen, r11_bad;
  bit  cur_lvl, prev_clk, prev_data;

  lnk_brk_init_seq u0 (
    .clk(clk), .rst_n(rst_n), .brk_start(brk_start), .init_start(init_start),
    .busy(busy), .done(done), .link_clk(link_clk), .link_data(link_data),
    .link_en(link_en), .link_mux(link_mux), .link_dir(link_dir)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_run();
    if (nruns < 8) begin
      run_lvl[nruns] = cur_lvl;
      run_len[nruns] = cur_len;
    end
    nruns++;
  endtask

  always @(negedge clk) begin
    if (!prev_clk && link_clk) begin
      if (cur_len == 0) begin cur_lvl = link_data; cur_len = 1; end
      else if (link_data != cur_lvl) begin push_run(); cur_lvl = link_data; cur_len = 1; end
      else cur_len++;
      since_rise = 0;
    end else since_rise++;
    if (rst_n && link_clk && prev_clk && (link_data != prev_data)) r11_bad++;
    prev_clk  = link_clk;
    prev_data = link_data;
    if (done) begin
      if (cur_len > 0) push_run();
      cur_len   = 0;
      done_k    = since_rise;
      done_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic clear_log();
    @(posedge clk);
    nruns = 0; cur_len = 0; since_rise = 0; done_seen = 0; done_k = -1;
    prev_clk = 1'b1; prev_data = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 100000 && done_seen == 0; i++) @(posedge clk);
  endtask

  task automatic check_break_shape();
    check(nruns == 3, "R4", nruns, 3);
    check(run_lvl[0] == 1'b1 && run_len[0] == 50, "R4", run_len[0], 50);
    check(run_lvl[1] == 1'b0 && run_len[1] == 256, "R5", run_len[1], 256);
    check(run_lvl[2] == 1'b1 && run_len[2] == 16016, "R6", run_len[2], 16016);
    check(done_k == WAIT_CYC + 1, "R7", done_k, WAIT_CYC + 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 0 && done == 0, "R1", {busy, done}, 0);
    check(link_clk == 1 && link_data == 1, "R1", {link_clk, link_data}, 3);
    check({link_en, link_mux, link_dir} == 3'b000, "R1", {link_en, link_mux, link_dir}, 0);
  endtask

  // R10: both requests in one idle cycle
  task automatic t_collide_idle();
    clear_log();
    @(negedge clk); brk_start = 1; init_start = 1;
    @(negedge clk); brk_start = 0; init_start = 0;
    check(busy == 1, "R8", busy, 1);
    check(link_en == 0, "R10", link_en, 0);
    wait_done();
    check_break_shape();
    @(negedge clk);
    check(busy == 0 && done == 0, "R8", {busy, done}, 0);
    check(link_en == 0 && link_dir == 0, "R10", {link_en, link_dir}, 0);
  endtask

  task automatic t_init();
    clear_log();
    @(negedge clk); init_start = 1;
    @(negedge clk); init_start = 0;
    check(busy == 1, "R8", busy, 1);
    check({link_en, link_mux, link_dir} == 3'b111, "R2", {link_en, link_mux, link_dir}, 7);
    wait_done();
    check(nruns == 1 && run_lvl[0] == 1'b1, "R3", nruns, 1);
    check(run_len[0] == 5000, "R3", run_len[0], 5000);
    check(done_k == 1, "R3", done_k, 1);
    @(negedge clk);
    check(busy == 0, "R8", busy, 0);
    check({link_en, link_mux, link_dir} == 3'b111, "R2", {link_en, link_mux, link_dir}, 7);
  endtask

  // R9: requests injected mid-break
  task automatic t_break_inject();
    clear_log();
    @(negedge clk); brk_start = 1;
    @(negedge clk); brk_start = 0;
    repeat (400) @(negedge clk);
    brk_start = 1; init_start = 1;
    @(negedge clk); brk_start = 0; init_start = 0;
    repeat (40000) @(negedge clk);
    brk_start = 1; init_start = 1;
    @(negedge clk); brk_start = 0; init_start = 0;
    wait_done();
    check_break_shape();
    repeat (5) @(negedge clk);
    check(busy == 0, "R9", busy, 0);
    check(done_seen == 1, "R9", done_seen, 1);
    check(r11_bad == 0, "R11", r11_bad, 0);
    check(link_clk == 1 && link_data == 1, "R11", {link_clk, link_data}, 3);
  endtask

  initial begin
    rst_n = 0; brk_start = 0; init_start = 0;
    nruns = 0; cur_len = 0; since_rise = 0; done_seen = 0; done_k = -1;
    r11_bad = 0; prev_clk = 1; prev_data = 1; cur_lvl = 1;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_collide_idle();
    t_init();
    t_break_inject();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule